// File: doc/BRIEF.md
# Single-Pass ROM Search Engine for a One-Wire Bus

This block carries out one pass of the ROM search on a one-wire bus. It finds one device's 64-bit ROM code and tells the caller where the next pass must branch. The engine does not time the bus itself. It asks a neighbouring slot timing engine for one bus operation at a time: either a bus reset with presence detection, or a single bit slot. A bit slot drives a write level and returns the level it samples.

The caller pulses `start` and supplies two values from the previous pass: the branch position and the ROM code that pass found. For the first pass the branch position is 0xFF and the code may be anything. When the pass ends, `done` pulses for one cycle with a status, the new ROM code and the branch position for the next pass. A branch position of 0 means the code just found belongs to the last device. The caller repeats passes until it sees that marker or an error.

Top module: `owsrch_engine`

## Requirements
- R1: A pass opens with one reset operation (`slot_op` = 0). If the returned `slot_rbit` is 0, meaning no presence pulse, the pass ends with status 1 (no device) and requests no further slots.
- R2: After a reset that sees presence, the engine sends the command code 0xF0 as eight bit slots, least significant bit first. The written levels are therefore 0,0,0,0,1,1,1,1.
- R3: The engine visits positions 64 down to 1. At each position it requests a read slot and then a complement slot, both with `slot_wbit` = 1, and then one write slot. A complete pass therefore uses 1 + 8 + 192 slots.
- R4: If the read and complement levels are both 1, the pass ends with status 2 (data error) and no write slot follows.
- R5: If the read and complement levels differ, the chosen bit is the read level.
- R6: If both levels are 0, there is a conflict. The engine chooses 1 when the previous branch position is greater than the current position. It also chooses 1 when the previous code's bit at this position is 1 and the position is not the previous branch position. In every other case it chooses 0.
- R7: Each conflict resolved to 1 overwrites the returned branch position with the current position. If no conflict resolved to 1, `disc_out` is 0.
- R8: The chosen bit is written in the write slot. `rom_out[k]` holds the bit chosen at position 64-k, so the first bit found is the least significant bit of byte 0.
- R9: `done` is a one-cycle pulse. `status`, `rom_out` and `disc_out` are valid in that cycle. The status codes are 0 = found, 1 = no device, 2 = data error.
- R10: A `start` pulse that arrives while a pass is running has no effect on that pass or on its result.
- R11: `slot_req` is a one-cycle pulse. The next request is issued only after `slot_ack` has answered the previous one. After reset, `done` and `slot_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass (accepted only when idle) |
| prev_disc | input | 8 | Branch position left by the previous pass (0xFF for the first pass) |
| prev_rom | input | 64 | ROM code found by the previous pass |
| done | output | 1 | One-cycle end-of-pass pulse |
| status | output | 2 | 0 found, 1 no device, 2 data error |
| rom_out | output | 64 | ROM code found in this pass |
| disc_out | output | 8 | Branch position for the next pass (0 = last device) |
| slot_req | output | 1 | Request pulse to the slot timing engine |
| slot_op | output | 1 | 0 = bus reset, 1 = bit slot |
| slot_wbit | output | 1 | Level to write in a bit slot (1 releases the bus) |
| slot_ack | input | 1 | Slot engine finished the requested operation |
| slot_rbit | input | 1 | Sampled bus level, or presence seen after a reset |

## Verification
Two updates can fall in the same cycle: recording a new branch position, and completing the pass, when the last conflict resolved to 1 sits at position 1. A three-device population is built in which a branch is taken at exactly that last position. The check judges that the pass ends with `disc_out` = 1 and the correct code, and that the branch position is not dropped at the boundary. A second overlap, a `start` pulse during a running pass, is judged by checking that the result matches a pass with no stray `start` and that exactly one `done` pulse occurs.

// File: rtl/owsrch_pkg.sv
package owsrch_pkg;

   typedef enum logic [1:0] {
      ST_FOUND   = 2'd0,
      ST_NODEV   = 2'd1,
      ST_DATAERR = 2'd2
   } srch_status_e;

   typedef enum logic {
      OP_RESET = 1'b0,
      OP_BIT   = 1'b1
   } slot_op_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RST,
      S_CMD,
      S_RD,
      S_CP,
      S_WR,
      S_DONE
   } srch_state_e;

endpackage

// File: rtl/owsrch_decide.sv
// Branch decision for one ROM position (combinational).
module owsrch_decide #(
   parameter int DISC_W = 8,
   parameter int POS_W  = 7
) (
   input  logic              rd_bit,
   input  logic              cp_bit,
   input  logic [POS_W-1:0]  pos,
   input  logic [DISC_W-1:0] prev_disc,
   input  logic              prev_bit,
   output logic              err,
   output logic              choose,
   output logic              take_disc
);
   logic              conflict;
   logic              pick_one;
   logic [DISC_W-1:0] pos_ext;

   assign pos_ext  = DISC_W'(pos);
   assign conflict = !rd_bit && !cp_bit;
   assign err      = rd_bit && cp_bit;
   assign pick_one = (prev_disc > pos_ext) || (prev_bit && (prev_disc != pos_ext));
   assign choose   = conflict ? pick_one : rd_bit;
   assign take_disc = conflict && pick_one;
endmodule

// File: rtl/owsrch_romreg.sv
// Storage of the previous code (read per position) and the code being found.
module owsrch_romreg #(
   parameter int ROM_BITS    = 64,
   parameter int POS_W       = 7,
   parameter bit STORE_SHIFT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [ROM_BITS-1:0] prev_in,
   input  logic                shift_en,
   input  logic                bit_in,
   input  logic [POS_W-1:0]    pos,
   output logic                prev_bit,
   output logic [ROM_BITS-1:0] found
);
   localparam int IDX_W = $clog2(ROM_BITS);

   logic [ROM_BITS-1:0] prev_q;
   logic [ROM_BITS-1:0] found_q;

   assign found = found_q;

   generate
      if (STORE_SHIFT) begin : g_shift
         logic unused_pos;
         assign unused_pos = ^pos;
         assign prev_bit   = prev_q[0];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q  <= '0;
               found_q <= '0;
            end else if (load) begin
               prev_q  <= prev_in;
               found_q <= '0;
            end else if (shift_en) begin
               prev_q  <= {1'b0, prev_q[ROM_BITS-1:1]};
               found_q <= {bit_in, found_q[ROM_BITS-1:1]};
            end
         end
      end else begin : g_index
         logic [POS_W-1:0] idx_full;
         logic [IDX_W-1:0] idx;
         logic             unused_idx;
         assign idx_full   = POS_W'(ROM_BITS) - pos;
         assign idx        = idx_full[IDX_W-1:0];
         assign unused_idx = ^idx_full;
         assign prev_bit   = prev_q[idx];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q  <= '0;
               found_q <= '0;
            end else if (load) begin
               prev_q  <= prev_in;
               found_q <= '0;
            end else if (shift_en) begin
               found_q[idx] <= bit_in;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/owsrch_ctrl.sv
// Pass sequencer: reset, command byte, read/complement/write triplets.
module owsrch_ctrl
   import owsrch_pkg::*;
#(
   parameter int                 ROM_BITS  = 64,
   parameter int                 DISC_W    = 8,
   parameter int                 POS_W     = 7,
   parameter int                 CMD_BITS  = 8,
   parameter logic [CMD_BITS-1:0] CMD_CODE = 'hF0,
   parameter logic [DISC_W-1:0]  LAST_MARK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DISC_W-1:0] prev_disc,
   output logic              slot_req,
   output logic              slot_op,
   output logic              slot_wbit,
   input  logic              slot_ack,
   input  logic              slot_rbit,
   output logic              done,
   output logic [1:0]        status,
   output logic [DISC_W-1:0] disc_out,
   output logic [POS_W-1:0]  pos,
   output logic [DISC_W-1:0] prev_disc_lat,
   output logic              rd_bit,
   output logic              load,
   output logic              shift_en,
   output logic              choice,
   input  logic              err,
   input  logic              choose,
   input  logic              take_disc
);
   localparam int CMD_W = $clog2(CMD_BITS);

   srch_state_e       state_q;
   srch_status_e      status_q;
   logic              pend_q;
   logic              ack_ok;
   logic [POS_W-1:0]  pos_q;
   logic [CMD_W-1:0]  cmd_q;
   logic              rd_q;
   logic              choice_q;
   logic [DISC_W-1:0] disc_q;
   logic [DISC_W-1:0] prev_disc_q;

   assign ack_ok    = slot_ack && pend_q;
   assign slot_req  = (state_q != S_IDLE) && (state_q != S_DONE) && !pend_q;
   assign slot_op   = (state_q == S_RST) ? OP_RESET : OP_BIT;
   assign done      = (state_q == S_DONE);
   assign status    = status_q;
   assign disc_out  = disc_q;
   assign pos       = pos_q;
   assign prev_disc_lat = prev_disc_q;
   assign rd_bit    = rd_q;
   assign choice    = choice_q;
   assign load      = (state_q == S_IDLE) && start;
   assign shift_en  = (state_q == S_WR) && ack_ok;

   always_comb begin
      case (state_q)
         S_CMD:   slot_wbit = CMD_CODE[cmd_q];
         S_WR:    slot_wbit = choice_q;
         default: slot_wbit = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         status_q    <= ST_FOUND;
         pend_q      <= 1'b0;
         pos_q       <= '0;
         cmd_q       <= '0;
         rd_q        <= 1'b0;
         choice_q    <= 1'b0;
         disc_q      <= LAST_MARK;
         prev_disc_q <= '0;
      end else begin
         if (slot_req)    pend_q <= 1'b1;
         else if (ack_ok) pend_q <= 1'b0;
         case (state_q)
            S_IDLE: if (start) begin
               prev_disc_q <= prev_disc;
               disc_q      <= LAST_MARK;
               state_q     <= S_RST;
            end
            S_RST: if (ack_ok) begin
               if (!slot_rbit) begin
                  status_q <= ST_NODEV;
                  state_q  <= S_DONE;
               end else begin
                  cmd_q   <= '0;
                  state_q <= S_CMD;
               end
            end
            S_CMD: if (ack_ok) begin
               if (cmd_q == CMD_W'(CMD_BITS - 1)) begin
                  pos_q   <= POS_W'(ROM_BITS);
                  state_q <= S_RD;
               end else begin
                  cmd_q <= cmd_q + 1'b1;
               end
            end
            S_RD: if (ack_ok) begin
               rd_q    <= slot_rbit;
               state_q <= S_CP;
            end
            S_CP: if (ack_ok) begin
               if (err) begin
                  status_q <= ST_DATAERR;
                  state_q  <= S_DONE;
               end else begin
                  choice_q <= choose;
                  if (take_disc) disc_q <= DISC_W'(pos_q);
                  state_q <= S_WR;
               end
            end
            S_WR: if (ack_ok) begin
               if (pos_q == POS_W'(1)) begin
                  status_q <= ST_FOUND;
                  state_q  <= S_DONE;
               end else begin
                  pos_q   <= pos_q - 1'b1;
                  state_q <= S_RD;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   p_req_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      slot_req |=> !slot_req);

   p_nodev_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_RST && ack_ok && !slot_rbit) |=> (done && status == 2'd1));

   p_dataerr_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_CP && ack_ok && rd_q && slot_rbit) |=> (done && status == 2'd2));

   p_disc_record_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_CP && ack_ok && take_disc) |=> (disc_out == DISC_W'($past(pos_q))));

   p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != S_IDLE) |=> $stable(prev_disc_q));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/owsrch_engine.sv
module owsrch_engine
   import owsrch_pkg::*;
#(
   parameter int                  ROM_BITS    = 64,
   parameter int                  DISC_W      = 8,
   parameter int                  CMD_BITS    = 8,
   parameter logic [CMD_BITS-1:0] CMD_CODE    = 'hF0,
   parameter logic [DISC_W-1:0]   LAST_MARK   = '0,
   parameter bit                  STORE_SHIFT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [DISC_W-1:0]   prev_disc,
   input  logic [ROM_BITS-1:0] prev_rom,
   output logic                done,
   output logic [1:0]          status,
   output logic [ROM_BITS-1:0] rom_out,
   output logic [DISC_W-1:0]   disc_out,
   output logic                slot_req,
   output logic                slot_op,
   output logic                slot_wbit,
   input  logic                slot_ack,
   input  logic                slot_rbit
);
   localparam int POS_W = $clog2(ROM_BITS + 1);

   generate
      if (ROM_BITS < 8 || (ROM_BITS % 8) != 0) begin : g_bad_rom
         $error("ROM_BITS must be a positive multiple of 8");
      end
      if (DISC_W < POS_W) begin : g_bad_disc
         $error("DISC_W too narrow for the position range");
      end
      if (CMD_BITS < 2) begin : g_bad_cmd
         $error("CMD_BITS must be at least 2");
      end
   endgenerate

   logic [POS_W-1:0]  pos;
   logic [DISC_W-1:0] prev_disc_lat;
   logic              rd_bit;
   logic              load;
   logic              shift_en;
   logic              choice;
   logic              prev_bit;
   logic              err;
   logic              choose;
   logic              take_disc;

   owsrch_ctrl #(
      .ROM_BITS (ROM_BITS),
      .DISC_W   (DISC_W),
      .POS_W    (POS_W),
      .CMD_BITS (CMD_BITS),
      .CMD_CODE (CMD_CODE),
      .LAST_MARK(LAST_MARK)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .prev_disc    (prev_disc),
      .slot_req     (slot_req),
      .slot_op      (slot_op),
      .slot_wbit    (slot_wbit),
      .slot_ack     (slot_ack),
      .slot_rbit    (slot_rbit),
      .done         (done),
      .status       (status),
      .disc_out     (disc_out),
      .pos          (pos),
      .prev_disc_lat(prev_disc_lat),
      .rd_bit       (rd_bit),
      .load         (load),
      .shift_en     (shift_en),
      .choice       (choice),
      .err          (err),
      .choose       (choose),
      .take_disc    (take_disc)
   );

   owsrch_decide #(
      .DISC_W(DISC_W),
      .POS_W (POS_W)
   ) u_decide (
      .rd_bit   (rd_bit),
      .cp_bit   (slot_rbit),
      .pos      (pos),
      .prev_disc(prev_disc_lat),
      .prev_bit (prev_bit),
      .err      (err),
      .choose   (choose),
      .take_disc(take_disc)
   );

   owsrch_romreg #(
      .ROM_BITS   (ROM_BITS),
      .POS_W      (POS_W),
      .STORE_SHIFT(STORE_SHIFT)
   ) u_romreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .prev_in (prev_rom),
      .shift_en(shift_en),
      .bit_in  (choice),
      .pos     (pos),
      .prev_bit(prev_bit),
      .found   (rom_out)
   );
endmodule

// File: tb/owsrch_engine_tb.sv
`timescale 1ns/1ps
module owsrch_engine_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  prev_disc = 8'hFF;
   logic [63:0] prev_rom = '0;
   logic        done;
   logic [1:0]  status;
   logic [63:0] rom_out;
   logic [7:0]  disc_out;
   logic        slot_req, slot_op, slot_wbit;
   logic        slot_ack = 1'b0;
   logic        slot_rbit = 1'b0;

   always #4 clk = ~clk;

   owsrch_engine u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .prev_disc(prev_disc),
      .prev_rom(prev_rom), .done(done), .status(status), .rom_out(rom_out),
      .disc_out(disc_out), .slot_req(slot_req), .slot_op(slot_op),
      .slot_wbit(slot_wbit), .slot_ack(slot_ack), .slot_rbit(slot_rbit)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   // bus population model
   logic [63:0] dev_rom [3];
   logic        dev_on  [3];
   logic        dev_act [3];
   int          slot_n = 0;
   int          slot_total = 0;
   int          err_at = -1;
   logic [7:0]  cmd_seen = '0;
   int          rel_bad = 0;
   int          done_cnt = 0;

   logic [1:0]  r_status;
   logic [63:0] r_rom;
   logic [7:0]  r_disc;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic bus_level(input int t, input logic inv);
      logic v = 1'b1;
      for (int d = 0; d < 3; d++)
         if (dev_act[d]) v = v & (inv ? ~dev_rom[d][t] : dev_rom[d][t]);
      return v;
   endfunction

   // slot timing engine model
   initial begin
      forever begin
         @(negedge clk);
         while (slot_req) begin
            logic v;
            int   t;
            int   ph;
            slot_total++;
            v = 1'b1;
            if (slot_op == 1'b0) begin
               v = 1'b0;
               for (int d = 0; d < 3; d++) begin
                  dev_act[d] = dev_on[d];
                  if (dev_on[d]) v = 1'b1;
               end
               slot_n = 0;
            end else begin
               if (slot_n < 8) begin
                  cmd_seen[slot_n] = slot_wbit;
               end else begin
                  t  = (slot_n - 8) / 3;
                  ph = (slot_n - 8) % 3;
                  if (ph < 2 && slot_wbit !== 1'b1) rel_bad++;
                  if (ph < 2 && t == err_at) v = 1'b1;
                  else if (ph == 0) v = bus_level(t, 1'b0);
                  else if (ph == 1) v = bus_level(t, 1'b1);
                  else begin
                     for (int d = 0; d < 3; d++)
                        if (dev_rom[d][t] != slot_wbit) dev_act[d] = 1'b0;
                     v = slot_wbit;
                  end
               end
               slot_n++;
            end
            repeat (2) @(negedge clk);
            slot_ack  = 1'b1;
            slot_rbit = v;
            @(negedge clk);
            slot_ack  = 1'b0;
         end
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         if (done === 1'b1) done_cnt++;
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
         end
      end
   end

   task automatic pulse_start(input logic [7:0] pd, input logic [63:0] pr);
      @(negedge clk);
      prev_disc = pd;
      prev_rom  = pr;
      start     = 1'b1;
      @(negedge clk);
      start     = 1'b0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (done !== 1'b1 && n < 5000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 5000) chk("R9 done timeout", 64'd0, 64'd1);
      r_status = status;
      r_rom    = rom_out;
      r_disc   = disc_out;
      @(negedge clk);
   endtask

   task automatic run_pass(input logic [7:0] pd, input logic [63:0] pr);
      slot_total = 0;
      rel_bad    = 0;
      cmd_seen   = '0;
      pulse_start(pd, pr);
      wait_done();
   endtask

   task automatic set_devs(input logic on0, input logic on1, input logic on2);
      dev_on[0] = on0; dev_on[1] = on1; dev_on[2] = on2;
   endtask

   task automatic t_reset_state();
      chk("R11 reset done", 64'(done), 64'd0);
      chk("R11 reset slot_req", 64'(slot_req), 64'd0);
   endtask

   task automatic t_no_device();
      int d0;
      set_devs(1'b0, 1'b0, 1'b0);
      d0 = done_cnt;
      run_pass(8'hFF, '0);
      chk("R1 status no device", 64'(r_status), 64'd1);
      chk("R1 slots used", 64'(slot_total), 64'd1);
      chk("R9 single done pulse", 64'(done_cnt - d0), 64'd1);
   endtask

   task automatic t_single();
      dev_rom[0] = 64'h3C5A_0F96_E1D2_7B84;
      set_devs(1'b1, 1'b0, 1'b0);
      run_pass(8'hFF, '0);
      chk("R9 status found", 64'(r_status), 64'd0);
      chk("R8 R5 code order", r_rom, 64'h3C5A_0F96_E1D2_7B84);
      chk("R7 last-device marker", 64'(r_disc), 64'd0);
      chk("R2 command bits", 64'(cmd_seen), 64'hF0);
      chk("R3 read slots release", 64'(rel_bad), 64'd0);
      chk("R3 slot count", 64'(slot_total), 64'd201);
   endtask

   task automatic t_three();
      dev_rom[0] = 64'h0;
      dev_rom[1] = 64'h1;
      dev_rom[2] = 64'h8000_0000_0000_0000;
      set_devs(1'b1, 1'b1, 1'b1);
      run_pass(8'hFF, '0);
      chk("R6 pass1 code", r_rom, 64'h1);
      chk("R7 pass1 branch", 64'(r_disc), 64'd64);
      run_pass(8'd64, 64'h1);
      chk("R6 pass2 code", r_rom, 64'h8000_0000_0000_0000);
      chk("R7 pass2 branch at position 1", 64'(r_disc), 64'd1);
      run_pass(8'd1, 64'h8000_0000_0000_0000);
      chk("R6 pass3 code", r_rom, 64'h0);
      chk("R7 pass3 last marker", 64'(r_disc), 64'd0);
   endtask

   task automatic t_data_error();
      dev_rom[0] = 64'h55;
      set_devs(1'b1, 1'b0, 1'b0);
      err_at = 5;
      run_pass(8'hFF, '0);
      err_at = -1;
      chk("R4 status data error", 64'(r_status), 64'd2);
      chk("R4 no write after error", 64'(slot_total), 64'd26);
   endtask

   task automatic t_start_busy();
      int d0;
      dev_rom[0] = 64'h0;
      dev_rom[1] = 64'h1;
      dev_rom[2] = 64'h8000_0000_0000_0000;
      set_devs(1'b1, 1'b1, 1'b1);
      d0 = done_cnt;
      slot_total = 0;
      pulse_start(8'hFF, '0);
      repeat (60) @(negedge clk);
      pulse_start(8'd64, 64'h1);
      wait_done();
      chk("R10 code unaffected", r_rom, 64'h1);
      chk("R10 branch unaffected", 64'(r_disc), 64'd64);
      chk("R10 one done only", 64'(done_cnt - d0), 64'd1);
      chk("R10 slot count", 64'(slot_total), 64'd201);
   endtask

   initial begin
      for (int d = 0; d < 3; d++) begin
         dev_rom[d] = '0;
         dev_on[d]  = 1'b0;
         dev_act[d] = 1'b0;
      end
      repeat (3) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_no_device();
      t_single();
      t_three();
      t_data_error();
      t_start_busy();
      repeat (5) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule